// File: doc/BRIEF.md
# Banked Gather/Scatter Memory Unit

This unit serves indexed vector memory instructions for a 16-lane SIMD datapath. A gather reads one word for each lane from that lane's address. A scatter writes each lane's data word to that lane's address. The storage is split into single-ported banks, and each bank is split into two sub-banks. Lanes that land in different banks or sub-banks are served in the same cycle. Lanes that present the same address within one sub-bank share a single access.

Each accepted instruction takes a slot in a small in-order completion window. The lane requests for each bank go into that bank's request buffer. The banks work through their buffers on their own, so an instruction can be served in some banks while an older one is still being served in others. When every lane of the oldest instruction has been served, the unit raises a completion pulse. For a gather, that pulse comes with all lane results, each in its own lane position. One cycle after acceptance, the unit reports the instruction's conflict count: the largest number of distinct addresses that fall into any one sub-bank. This count is the number of service cycles the instruction needs when it runs alone.

Top module: `gs_unit`

## Requirements
- R1: With the default 8 banks, a word address `a` maps to bank `a[2:0]`, sub-bank `a[3]` and row `a[7:4]`. Lanes in different bank/sub-bank pairs are served in the same cycle.
- R2: One cycle after an instruction is accepted, `o_cnt_vld` pulses high. `o_cnt` then holds the maximum, over all bank/sub-bank pairs, of the number of distinct lane addresses that map to that pair.
- R3: An instruction issued while the unit is idle raises `o_done` exactly `o_cnt + 1` clock edges after the edge that accepted it.
- R4: A gather whose lanes all use one address has a count of 1, and every lane receives the same stored word.
- R5: When lanes of a scatter write the same address, the word stored is the data of the highest-numbered of those lanes.
- R6: A gather places the result for lane `i` in `o_rdata[i*DW +: DW]`. That result is the value written by the last scatter to that address accepted before the gather.
- R7: `o_ready` is low while DEPTH instructions are outstanding, or while any bank buffer the offered instruction targets is full. An instruction offered while `o_ready` is low is not accepted, and no count is reported for it.
- R8: Completions occur in acceptance order. A stream of count-1 instructions accepted on consecutive cycles completes on consecutive cycles.
- R9: After reset, `o_ready` is 1 and both `o_done` and `o_cnt_vld` are 0.
- R10: `o_done_gather` is 1 with the completion of a gather and 0 with the completion of a scatter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_valid | input | 1 | Instruction offered |
| i_gather | input | 1 | 1 = gather, 0 = scatter |
| i_addr | input | LANES*AW | Lane word addresses, lane i at bits i*AW |
| i_wdata | input | LANES*DW | Scatter data, lane i at bits i*DW |
| o_ready | output | 1 | Instruction is accepted at the next edge if i_valid |
| o_cnt_vld | output | 1 | Conflict count valid |
| o_cnt | output | $clog2(LANES+1) | Conflict count of the last accepted instruction |
| o_done | output | 1 | Oldest instruction completed |
| o_done_gather | output | 1 | Completed instruction was a gather |
| o_rdata | output | LANES*DW | Gathered lane results |

## Verification
Two functions can fall in the same cycle: the acceptance of a new instruction, and the service and retirement of older instructions whose requests share the bank buffers with it. The bench provokes this with back-to-back streams. These include count-1 streams that must complete on consecutive cycles, four maximum-conflict instructions that fill the completion window, and a long run of random instructions with varied address spread. Each completion is matched in order against a reference memory that is updated at issue time. The exact latency is also checked wherever the expected schedule is known.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic {
    OP_SCATTER = 1'b0,
    OP_GATHER  = 1'b1
  } gs_op_e;
endpackage

// File: rtl/gs_conflict.sv
module gs_conflict #(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int BB    = 3,
  localparam int CW   = $clog2(LANES + 1),
  localparam int NPAIR = 1 << (BB + 1)
) (
  input  logic [LANES*AW-1:0] addr,
  output logic [CW-1:0]       cnt
);
  logic [LANES-1:0] first;

  // a lane is the first holder of its address when no lower lane shares it
  always_comb begin
    first = '0;
    for (int i = 0; i < LANES; i++) begin
      first[i] = 1'b1;
      for (int j = 0; j < i; j++)
        if (addr[j*AW +: AW] == addr[i*AW +: AW]) first[i] = 1'b0;
    end
  end

  // distinct addresses per {sub, bank} pair, then the maximum
  always_comb begin
    logic [CW-1:0] tally;
    cnt = '0;
    for (int p = 0; p < NPAIR; p++) begin
      tally = '0;
      for (int i = 0; i < LANES; i++)
        if (first[i] && (addr[i*AW +: BB+1] == p[BB:0])) tally = tally + CW'(1);
      if (tally > cnt) cnt = tally;
    end
  end
endmodule

// File: rtl/gs_bank.sv
module gs_bank #(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  parameter int BB    = 3,
  localparam int TW   = $clog2(DEPTH),
  localparam int NW   = $clog2(DEPTH + 1),
  localparam int RW   = AW - BB - 1,
  localparam int ROWS = 1 << RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [TW-1:0]     push_tag,
  input  logic [LANES-1:0]  push_mask,
  output logic              full,
  output logic [TW-1:0]     head_tag,
  input  logic              head_wr,
  input  logic [LANES*AW-1:0] head_addr,
  input  logic [LANES*DW-1:0] head_wdata,
  output logic [2*LANES-1:0] srv_mask,
  output logic [2*DW-1:0]   srv_data
);
  logic [TW-1:0]    tag_q  [DEPTH];
  logic [LANES-1:0] left_q [DEPTH];
  logic [TW-1:0]    rd_q, rd_d, wr_q, wr_d;
  logic [NW-1:0]    num_q, num_d;
  logic [DW-1:0]    mem [2][ROWS];

  logic             head_vld, pop;
  logic [LANES-1:0] hit   [2];
  logic [RW-1:0]    row   [2];
  logic [DW-1:0]    wword [2];
  logic [LANES-1:0] remain;

  assign head_vld = (num_q != '0);
  assign full     = (num_q == NW'(DEPTH));
  assign head_tag = tag_q[rd_q];

  // per sub-bank: lowest pending lane leads, all lanes on its address ride along
  always_comb begin
    logic [LANES-1:0] cand;
    logic [AW-1:0]    lead;
    for (int s = 0; s < 2; s++) begin
      cand = '0;
      lead = '0;
      for (int i = 0; i < LANES; i++)
        if (head_vld && left_q[rd_q][i] && (head_addr[i*AW+BB] == s[0])) cand[i] = 1'b1;
      for (int i = LANES - 1; i >= 0; i--)
        if (cand[i]) lead = head_addr[i*AW +: AW];
      hit[s]   = '0;
      wword[s] = '0;
      for (int i = 0; i < LANES; i++)
        if (cand[i] && (head_addr[i*AW +: AW] == lead)) begin
          hit[s][i] = 1'b1;
          wword[s]  = head_wdata[i*DW +: DW];
        end
      row[s] = lead[AW-1:BB+1];
    end
  end

  assign srv_mask = {hit[1], hit[0]};
  assign srv_data = {mem[1][row[1]], mem[0][row[0]]};
  assign remain   = left_q[rd_q] & ~(hit[0] | hit[1]);
  assign pop      = head_vld && (remain == '0);

  always_comb begin
    rd_d  = pop  ? rd_q + TW'(1) : rd_q;
    wr_d  = push ? wr_q + TW'(1) : wr_q;
    num_d = num_q + NW'(push) - NW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      num_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      num_q <= num_d;
    end
  end

  always_ff @(posedge clk) begin
    if (head_vld) left_q[rd_q] <= remain;
    if (push) begin
      tag_q[wr_q]  <= push_tag;
      left_q[wr_q] <= push_mask;
    end
    for (int s = 0; s < 2; s++)
      if (head_wr && (hit[s] != '0)) mem[s][row[s]] <= wword[s];
  end

  // R7: the issue side never pushes into a full buffer
  p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full bank buffer");
endmodule

// File: rtl/gs_unit.sv
module gs_unit
  import gs_pkg::*;
#(
  parameter int LANES = 16,
  parameter int NBANK = 8,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int BB   = $clog2(NBANK),
  localparam int TW   = $clog2(DEPTH),
  localparam int OW   = $clog2(DEPTH + 1),
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                i_valid,
  input  logic                i_gather,
  input  logic [LANES*AW-1:0] i_addr,
  input  logic [LANES*DW-1:0] i_wdata,
  output logic                o_ready,
  output logic                o_cnt_vld,
  output logic [CW-1:0]       o_cnt,
  output logic                o_done,
  output logic                o_done_gather,
  output logic [LANES*DW-1:0] o_rdata
);
  gs_op_e              s_op    [DEPTH];
  logic [LANES*AW-1:0] s_addr  [DEPTH];
  logic [LANES*DW-1:0] s_wdata [DEPTH];
  logic [LANES*DW-1:0] s_rdata [DEPTH];
  logic [LANES-1:0]    pend_q  [DEPTH];
  logic [LANES-1:0]    pend_d  [DEPTH];
  logic [TW-1:0]       hd_q, hd_d, tl_q, tl_d;
  logic [OW-1:0]       occ_q, occ_d;

  logic [LANES-1:0]    lane_in [NBANK];
  logic [NBANK-1:0]    bk_full;
  logic [TW-1:0]       bk_tag  [NBANK];
  logic [2*LANES-1:0]  bk_srv  [NBANK];
  logic [2*DW-1:0]     bk_dat  [NBANK];
  logic [CW-1:0]       cnt_c;
  logic                tgt_full, acc, retire;

  gs_conflict #(.LANES(LANES), .AW(AW), .BB(BB)) u_conf (
    .addr(i_addr), .cnt(cnt_c)
  );

  always_comb begin
    tgt_full = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      for (int i = 0; i < LANES; i++)
        lane_in[b][i] = (i_addr[i*AW +: BB] == BB'(b));
      if ((lane_in[b] != '0) && bk_full[b]) tgt_full = 1'b1;
    end
  end

  assign o_ready = (occ_q != OW'(DEPTH)) && !tgt_full;
  assign acc     = i_valid && o_ready;
  assign retire  = (occ_q != '0) && (pend_q[hd_q] == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    gs_bank #(.LANES(LANES), .AW(AW), .DW(DW), .DEPTH(DEPTH), .BB(BB)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (acc && (lane_in[b] != '0)),
      .push_tag   (tl_q),
      .push_mask  (lane_in[b]),
      .full       (bk_full[b]),
      .head_tag   (bk_tag[b]),
      .head_wr    (s_op[bk_tag[b]] == OP_SCATTER),
      .head_addr  (s_addr[bk_tag[b]]),
      .head_wdata (s_wdata[bk_tag[b]]),
      .srv_mask   (bk_srv[b]),
      .srv_data   (bk_dat[b])
    );
  end

  always_comb begin
    pend_d = pend_q;
    for (int b = 0; b < NBANK; b++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < LANES; i++)
          if (bk_srv[b][s*LANES+i]) pend_d[bk_tag[b]][i] = 1'b0;
    if (acc) pend_d[tl_q] = '1;
    tl_d  = acc    ? tl_q + TW'(1) : tl_q;
    hd_d  = retire ? hd_q + TW'(1) : hd_q;
    occ_d = occ_q + OW'(acc) - OW'(retire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) pend_q[k] <= '0;
      hd_q          <= '0;
      tl_q          <= '0;
      occ_q         <= '0;
      o_cnt_vld     <= 1'b0;
      o_done        <= 1'b0;
    end else begin
      pend_q        <= pend_d;
      hd_q          <= hd_d;
      tl_q          <= tl_d;
      occ_q         <= occ_d;
      o_cnt_vld     <= acc;
      o_done        <= retire;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      s_op[tl_q]    <= gs_op_e'(i_gather);
      s_addr[tl_q]  <= i_addr;
      s_wdata[tl_q] <= i_wdata;
      o_cnt         <= cnt_c;
    end
    if (retire) begin
      o_done_gather <= (s_op[hd_q] == OP_GATHER);
      o_rdata       <= s_rdata[hd_q];
    end
    for (int b = 0; b < NBANK; b++)
      for (int s = 0; s < 2; s++)
        for (int i = 0; i < LANES; i++)
          if (bk_srv[b][s*LANES+i]) s_rdata[bk_tag[b]][i*DW +: DW] <= bk_dat[b][s*DW +: DW];
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_cnt_vld |-> (o_cnt != '0) && (o_cnt <= CW'(LANES))) else $error("count out of range");

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !o_ready) |=> !o_cnt_vld) else $error("held instruction reported");

  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(DEPTH)) else $error("completion window overflow");

  p_done_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_done |-> ($past(occ_q) != '0)) else $error("completion with empty window");
endmodule

// File: tb/sim_gs_unit.sv
module sim_gs_unit;
  localparam int LANES = 16;
  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int QN    = 512;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                i_valid = 1'b0;
  logic                i_gather = 1'b0;
  logic [LANES*AW-1:0] i_addr = '0;
  logic [LANES*DW-1:0] i_wdata = '0;
  logic                o_ready, o_cnt_vld, o_done, o_done_gather;
  logic [4:0]          o_cnt;
  logic [LANES*DW-1:0] o_rdata;

  gs_unit u0 (
    .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_gather(i_gather),
    .i_addr(i_addr), .i_wdata(i_wdata), .o_ready(o_ready), .o_cnt_vld(o_cnt_vld),
    .o_cnt(o_cnt), .o_done(o_done), .o_done_gather(o_done_gather), .o_rdata(o_rdata)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0]       refm [256];
  logic [LANES*AW-1:0] va;
  logic [LANES*DW-1:0] vd;

  int                  c_exp [QN];
  string               c_tag [QN];
  int                  c_hd = 0, c_tl = 0;
  logic                d_g   [QN];
  logic [LANES*DW-1:0] d_dat [QN];
  int                  d_acc [QN];
  int                  d_cnt [QN];
  bit                  d_iso [QN];
  string               d_dtag [QN];
  string               d_ltag [QN];
  int                  d_hd = 0, d_tl = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_cnt(input logic [LANES*AW-1:0] a);
    int best;
    int n;
    bit dup;
    best = 0;
    for (int p = 0; p < 16; p++) begin
      n = 0;
      for (int i = 0; i < LANES; i++) begin
        if (a[i*AW +: 4] == p[3:0]) begin
          dup = 1'b0;
          for (int j = 0; j < i; j++)
            if (a[j*AW +: AW] == a[i*AW +: AW]) dup = 1'b1;
          if (!dup) n++;
        end
      end
      if (n > best) best = n;
    end
    return best;
  endfunction

  // offer va/vd, record expectations, return right after the accepting edge
  task automatic issue(input bit g, input bit iso, input string ctag, input string dtag, input string ltag);
    logic [LANES*DW-1:0] res;
    @(negedge clk);
    i_valid = 1'b1; i_gather = g; i_addr = va; i_wdata = vd;
    while (!o_ready) @(negedge clk);
    res = '0;
    for (int i = 0; i < LANES; i++) res[i*DW +: DW] = refm[va[i*AW +: AW]];
    if (!g) for (int i = 0; i < LANES; i++) refm[va[i*AW +: AW]] = vd[i*DW +: DW];
    c_exp[c_tl % QN] = exp_cnt(va); c_tag[c_tl % QN] = ctag; c_tl++;
    d_g[d_tl % QN] = g; d_dat[d_tl % QN] = res; d_acc[d_tl % QN] = cyc;
    d_cnt[d_tl % QN] = exp_cnt(va); d_iso[d_tl % QN] = iso;
    d_dtag[d_tl % QN] = dtag; d_ltag[d_tl % QN] = ltag; d_tl++;
    @(posedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    i_valid = 1'b0;
    while (d_hd != d_tl) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && o_cnt_vld) begin
      if (c_hd == c_tl) chk(1'b0, "R7 unexpected count", 1, 0);
      else begin
        chk(o_cnt == 5'(c_exp[c_hd % QN]), c_tag[c_hd % QN], longint'(o_cnt), longint'(c_exp[c_hd % QN]));
        c_hd++;
      end
    end
    if (rst_n && o_done) begin
      if (d_hd == d_tl) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        int k;
        k = d_hd % QN;
        chk(o_done_gather == d_g[k], "R10", longint'(o_done_gather), longint'(d_g[k]));
        if (d_g[k])
          for (int i = 0; i < LANES; i++)
            chk(o_rdata[i*DW +: DW] == d_dat[k][i*DW +: DW], d_dtag[k],
                longint'(o_rdata[i*DW +: DW]), longint'(d_dat[k][i*DW +: DW]));
        if (d_iso[k])
          chk(cyc == d_acc[k] + d_cnt[k] + 2, d_ltag[k], longint'(cyc), longint'(d_acc[k] + d_cnt[k] + 2));
        d_hd++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9
    chk(o_ready == 1'b1, "R9 ready", longint'(o_ready), 1);
    chk(o_done == 1'b0, "R9 done", longint'(o_done), 0);
    chk(o_cnt_vld == 1'b0, "R9 cnt_vld", longint'(o_cnt_vld), 0);

    // fill the whole memory: every pair once per scatter, count 1 (R1)
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < LANES; i++) begin
        va[i*AW +: AW] = AW'(k*16 + i);
        vd[i*DW +: DW] = DW'($urandom);
      end
      issue(1'b0, 1'b0, "R1 spread", "R6", "R3");
    end
    wait_idle();

    // all distinct pairs: count 1, latency 2 (R1, R3, R6)
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(8'h50 + i);
    issue(1'b1, 1'b1, "R1 distinct", "R6", "R3");
    wait_idle();

    // one address for all lanes (R4)
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = 8'd37;
    issue(1'b1, 1'b1, "R4 count", "R4", "R3");
    wait_idle();

    // all lanes in bank 0, both sub-banks: 8 per sub (R1, R3)
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(i << 3);
    issue(1'b1, 1'b1, "R1 bank0", "R6", "R3");
    wait_idle();

    // all lanes in bank 0 sub 0, reversed lane order: count 16 (R6)
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'((15 - i) << 4);
    issue(1'b1, 1'b1, "R2 worst", "R6", "R3");
    wait_idle();

    // merged scatter, highest lane wins (R5)
    for (int i = 0; i < LANES; i++) begin
      va[i*AW +: AW] = 8'd77;
      vd[i*DW +: DW] = DW'(16'h1000 + i);
    end
    issue(1'b0, 1'b1, "R5 count", "R5", "R3");
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(i == 3 ? 77 : 8'h80 + i);
    issue(1'b1, 1'b0, "R5 mixed", "R5", "R3");
    wait_idle();
    chk(refm[77] == 16'h100f, "R5 reference", longint'(refm[77]), 64'h100f);

    // back-to-back count-1 stream (R8)
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(k*16 + ((i + k) % 16));
      issue(1'b1, 1'b1, "R8 count", "R8", "R8");
    end
    wait_idle();

    // fill the completion window, then offer a fifth (R7)
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(i << 4);
      issue(1'b1, 1'b0, "R7 count", "R6", "R3");
    end
    for (int i = 0; i < LANES; i++) va[i*AW +: AW] = AW'(8'h21 + i);
    @(negedge clk);
    i_addr = va;
    chk(o_ready == 1'b0, "R7 window full", longint'(o_ready), 0);
    issue(1'b1, 1'b0, "R7 held", "R6", "R3");
    wait_idle();

    // random mix with varied spread
    for (int n = 0; n < 80; n++) begin
      int mode;
      mode = $urandom % 3;
      for (int i = 0; i < LANES; i++) begin
        logic [7:0] r;
        r = 8'($urandom);
        if (mode == 1) r = r & 8'h33;
        if (mode == 2) r = {r[7:4], 1'b0, 3'($urandom % 2)};
        va[i*AW +: AW] = r;
        vd[i*DW +: DW] = DW'($urandom);
      end
      issue(1'($urandom % 2), 1'b0, "R2 random", "R6", "R3");
    end
    wait_idle();

    chk(d_hd == d_tl, "R8 all completed", longint'(d_hd), longint'(d_tl));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule